// File: doc/BRIEF.md
# Edge-Triggered Interrupt Status Controller

This block collects asynchronous event lines from a small mixed-signal peripheral, such as an ADC conversion-done strobe and a touch-plate comparator, and turns selected transitions into latched status bits and one interrupt line. Each line passes through a synchronizer before its edges are detected. Two enable registers pick the edges that count for each bit: one for low-to-high transitions and one for high-to-low transitions. Setting both bits makes either transition count.

Software works through a simple synchronous register port. It reads one shared address to see which events are pending. It writes that same address to clear them. A written mask is held as a clear for as long as it stays in the register, and software releases it by writing zero. The interrupt output stays high while any status bit is latched.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After reset all status bits, both enable registers and the held clear mask are zero, irq_o is low and reg_rdata is zero.
- R2: A low-to-high transition on a source bit whose rising-enable bit (register at address 0x5E) is set latches that status bit. The bit becomes visible on the third rising clock edge after the input changes. A steady level latches nothing further.
- R3: A high-to-low transition on a source bit whose falling-enable bit (register at address 0x60) is set latches that status bit, with the same latency as R2. A transition whose enable is clear latches nothing.
- R4: When both enable bits of a source are set, each transition in either direction latches the status bit.
- R5: A write to address 0x62 stores the written mask as a held clear. From the next cycle, every masked status bit reads zero, and edges on masked bits that arrive while the clear is held are discarded. After a write of zero releases the clear, later edges latch again.
- R6: Writing 0xFFFF to address 0x62 clears every status bit.
- R7: irq_o is high exactly while at least one status bit is set, so it rises in the cycle in which an enabled event is first latched.
- R8: Clearing an enable bit stops new latching on that source only. Status that is already set stays set, and irq_o stays high.
- R9: A read strobe loads reg_rdata on the next clock edge: the rising-enable register for 0x5E, the falling-enable register for 0x60, the status for 0x62, and zero for any other address. Without a strobe, reg_rdata holds its value. Writes to other addresses change no register.
- R10: adc_done_i drives source bit 11 and pen_cmp_i drives source bit 12. Transitions on aux_src_i at those two positions are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| aux_src_i | input | NSRC | General event lines; bits ADC_BIT and PEN_BIT are not used |
| adc_done_i | input | 1 | ADC conversion-complete event line (source bit 11) |
| pen_cmp_i | input | 1 | Touch-plate comparator line (source bit 12) |
| reg_addr | input | ADDR_W | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | NSRC | Write data |
| reg_rdata | output | NSRC | Read data, registered |
| irq_o | output | 1 | Interrupt request, high while any status bit is set |

## Verification
The bench builds the block with its default values: sixteen sources, a two-stage synchronizer and the register addresses 0x5E, 0x60 and 0x62. With these values the full 0xFFFF clear mask can be tested, the dedicated ADC and comparator bits can be checked at positions 11 and 12, and the fixed three-edge latency from a source input to a status bit can be measured. The reference model keeps a short history of sampled sources, so edges that arrive during a held clear, or in the same cycle as a register write, are predicted without help from the design.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  // One source bit: does the current/previous pair form an enabled edge?
  function automatic logic edge_hit(input logic cur, input logic prev,
                                    input logic ren, input logic fen);
    logic up, down;
    up   = cur & ~prev;
    down = ~cur & prev;
    return (up & ren) | (down & fen);
  endfunction

  // One status bit: the held clear wins over a new event.
  function automatic logic latch_next(input logic stat, input logic hit,
                                      input logic clr);
    return clr ? 1'b0 : (stat | hit);
  endfunction

endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int LAST = STAGES - 1;

  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[LAST];
endmodule

// File: rtl/irqc_edge.sv
module irqc_edge
  import irqc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] rise_en,
  input  logic [W-1:0] fall_en,
  output logic [W-1:0] hit
);
  logic [W-1:0] prev;

  always_ff @(posedge clk) begin
    if (!rst_n) prev <= '0;
    else        prev <= cur;
  end

  for (genvar b = 0; b < W; b++) begin : g_bit
    assign hit[b] = edge_hit(cur[b], prev[b], rise_en[b], fall_en[b]);
  end
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
#(
  parameter int          W         = 16,
  parameter int          AW        = 8,
  parameter logic [7:0]  ADDR_RISE = 8'h5E,
  parameter logic [7:0]  ADDR_FALL = 8'h60,
  parameter logic [7:0]  ADDR_STAT = 8'h62
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr,
  input  logic          rd,
  input  logic [W-1:0]  wdata,
  input  logic [W-1:0]  hit,
  output logic [W-1:0]  rdata,
  output logic [W-1:0]  rise_en,
  output logic [W-1:0]  fall_en,
  output logic [W-1:0]  clr_hold,
  output logic [W-1:0]  status
);
  localparam logic [AW-1:0] A_RISE = AW'(ADDR_RISE);
  localparam logic [AW-1:0] A_FALL = AW'(ADDR_FALL);
  localparam logic [AW-1:0] A_STAT = AW'(ADDR_STAT);

  logic          sel_rise, sel_fall, sel_stat;
  logic [W-1:0]  rd_mux;
  logic [W-1:0]  status_nx;

  assign sel_rise = (addr == A_RISE);
  assign sel_fall = (addr == A_FALL);
  assign sel_stat = (addr == A_STAT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rise_en  <= '0;
      fall_en  <= '0;
      clr_hold <= '0;
    end else if (wr) begin
      if (sel_rise) rise_en  <= wdata;
      if (sel_fall) fall_en  <= wdata;
      if (sel_stat) clr_hold <= wdata;
    end
  end

  for (genvar b = 0; b < W; b++) begin : g_stat
    assign status_nx[b] = latch_next(status[b], hit[b], clr_hold[b]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) status <= '0;
    else        status <= status_nx;
  end

  always_comb begin
    rd_mux = '0;
    if (sel_rise)      rd_mux = rise_en;
    else if (sel_fall) rd_mux = fall_en;
    else if (sel_stat) rd_mux = status;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  rdata <= '0;
    else if (rd) rdata <= rd_mux;
  end
endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl #(
  parameter int         NSRC        = 16,
  parameter int         ADDR_W      = 8,
  parameter int         SYNC_STAGES = 2,
  parameter int         ADC_BIT     = 11,
  parameter int         PEN_BIT     = 12,
  parameter logic [7:0] ADDR_RISE   = 8'h5E,
  parameter logic [7:0] ADDR_FALL   = 8'h60,
  parameter logic [7:0] ADDR_STAT   = 8'h62
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   aux_src_i,
  input  logic              adc_done_i,
  input  logic              pen_cmp_i,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [NSRC-1:0]   reg_wdata,
  output logic [NSRC-1:0]   reg_rdata,
  output logic              irq_o
);
  logic [NSRC-1:0] raw_src;
  logic [NSRC-1:0] sync_src;
  logic [NSRC-1:0] rise_en, fall_en;
  logic [NSRC-1:0] hit_vec;
  logic [NSRC-1:0] clr_hold;
  logic [NSRC-1:0] status;

  always_comb begin
    raw_src          = aux_src_i;
    raw_src[ADC_BIT] = adc_done_i;
    raw_src[PEN_BIT] = pen_cmp_i;
  end

  irqc_sync #(.W(NSRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_src), .q(sync_src)
  );

  irqc_edge #(.W(NSRC)) u_edge (
    .clk(clk), .rst_n(rst_n), .cur(sync_src),
    .rise_en(rise_en), .fall_en(fall_en), .hit(hit_vec)
  );

  irqc_regs #(
    .W(NSRC), .AW(ADDR_W),
    .ADDR_RISE(ADDR_RISE), .ADDR_FALL(ADDR_FALL), .ADDR_STAT(ADDR_STAT)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr(reg_wr), .rd(reg_rd),
    .wdata(reg_wdata), .hit(hit_vec), .rdata(reg_rdata),
    .rise_en(rise_en), .fall_en(fall_en), .clr_hold(clr_hold), .status(status)
  );

  assign irq_o = |status;
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] hit,
  input logic [W-1:0] clr_hold,
  input logic [W-1:0] status,
  input logic         irq,
  input logic         rd_en,
  input logic [W-1:0] rd_data
);
  // R5: a held clear empties its bits on the following cycle
  a_r5_clear_held: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & $past(clr_hold)) == '0));

  // R8: latched bits stay set unless a clear was held
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(status) & ~$past(clr_hold)) & ~status) == '0));

  // R2: a newly set status bit needs an enabled edge in the cycle before
  a_r2_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((status & ~$past(status)) & ~$past(hit)) == '0));

  // R7: the interrupt only rises after an enabled edge
  a_r7_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(hit) != '0));

  // R9: read data holds without a strobe
  a_r9_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
endmodule

bind edge_irq_ctrl irqc_chk #(.W(NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .hit(hit_vec), .clr_hold(clr_hold),
  .status(status), .irq(irq_o), .rd_en(reg_rd), .rd_data(reg_rdata)
);

// File: tb/edge_irq_ctrl_test.sv
`timescale 1ns/1ps
module edge_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] aux = '0;
  logic        adc = 1'b0, pen = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  edge_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .aux_src_i(aux), .adc_done_i(adc),
    .pen_cmp_i(pen), .reg_addr(addr), .reg_wr(wr), .reg_rd(rd),
    .reg_wdata(wdata), .reg_rdata(rdata), .irq_o(irq)
  );

  // behavioural reference model
  logic [15:0] hist[$];
  logic [15:0] m_ren, m_fen, m_clr, m_stat, m_rd;

  function automatic logic [15:0] merged();
    logic [15:0] v;
    v = aux;
    v[11] = adc;
    v[12] = pen;
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      hist = {16'h0, 16'h0, 16'h0};
      m_ren = 0; m_fen = 0; m_clr = 0; m_stat = 0; m_rd = 0;
    end else begin
      logic [15:0] nstat;
      for (int b = 0; b < 16; b++) begin
        bit now_v, old_v, ev;
        now_v = hist[1][b];
        old_v = hist[2][b];
        ev = (now_v && !old_v && m_ren[b]) || (!now_v && old_v && m_fen[b]);
        if (m_clr[b]) nstat[b] = 1'b0;
        else          nstat[b] = m_stat[b] || ev;
      end
      if (rd) begin
        case (addr)
          8'h5E:   m_rd = m_ren;
          8'h60:   m_rd = m_fen;
          8'h62:   m_rd = m_stat;
          default: m_rd = 16'h0;
        endcase
      end
      if (wr) begin
        case (addr)
          8'h5E: m_ren = wdata;
          8'h60: m_fen = wdata;
          8'h62: m_clr = wdata;
          default: ;
        endcase
      end
      m_stat = nstat;
      hist.push_front(merged());
      void'(hist.pop_back());
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (irq !== (m_stat != 0)) begin
        fails++;
        $display("FAIL R7 irq_o actual=%0b expected=%0b", irq, (m_stat != 0));
      end
      checks++;
      if (rdata !== m_rd) begin
        fails++;
        $display("FAIL R9 reg_rdata actual=%h expected=%h", rdata, m_rd);
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wreg(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rchk(input logic [7:0] a, input logic [15:0] exp, input string req);
    @(negedge clk);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    checks++;
    if (rdata !== exp) begin
      fails++;
      $display("FAIL %s read %h actual=%h expected=%h", req, a, rdata, exp);
    end
  endtask

  task automatic irqchk(input logic exp, input string req);
    checks++;
    if (irq !== exp) begin
      fails++;
      $display("FAIL %s irq_o actual=%0b expected=%0b", req, irq, exp);
    end
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    cyc(4);
    rst_n = 1'b1;
    cyc(1);
    // R1 reset state
    irqchk(1'b0, "R1");
    rchk(8'h5E, 16'h0, "R1");
    rchk(8'h60, 16'h0, "R1");
    rchk(8'h62, 16'h0, "R1");

    // R2/R10 rising edge of ADC line on bit 11, latency of three edges
    wreg(8'h5E, 16'h0800);
    @(negedge clk); adc = 1'b1;
    cyc(2);
    irqchk(1'b0, "R2");
    cyc(1);
    irqchk(1'b1, "R2");
    cyc(4);
    rchk(8'h62, 16'h0800, "R10");
    // R3 falling edge without fall enable: no new bits
    @(negedge clk); adc = 1'b0;
    cyc(5);
    rchk(8'h62, 16'h0800, "R3");

    // R5 held clear discards edges, release re-arms
    wreg(8'h62, 16'h0800);
    cyc(1);
    rchk(8'h62, 16'h0000, "R5");
    @(negedge clk); adc = 1'b1;
    cyc(6);
    rchk(8'h62, 16'h0000, "R5");
    irqchk(1'b0, "R7");
    wreg(8'h62, 16'h0000);
    @(negedge clk); adc = 1'b0;
    cyc(3);
    @(negedge clk); adc = 1'b1;
    cyc(5);
    rchk(8'h62, 16'h0800, "R5");
    wreg(8'h62, 16'h0800);
    wreg(8'h62, 16'h0000);

    // R3/R10 comparator falling edge on bit 12; aux bit 12 ignored
    wreg(8'h5E, 16'h0000);
    wreg(8'h60, 16'h1000);
    @(negedge clk); pen = 1'b1;
    cyc(5);
    rchk(8'h62, 16'h0000, "R3");
    @(negedge clk); pen = 1'b0;
    cyc(5);
    rchk(8'h62, 16'h1000, "R3");
    wreg(8'h62, 16'hFFFF);
    wreg(8'h62, 16'h0000);
    @(negedge clk); aux[12] = 1'b1;
    cyc(4);
    @(negedge clk); aux[12] = 1'b0;
    cyc(5);
    rchk(8'h62, 16'h0000, "R10");

    // R4 both directions on bit 3
    wreg(8'h5E, 16'h0008);
    wreg(8'h60, 16'h0008);
    @(negedge clk); aux[3] = 1'b1;
    cyc(5);
    rchk(8'h62, 16'h0008, "R4");
    wreg(8'h62, 16'h0008);
    wreg(8'h62, 16'h0000);
    @(negedge clk); aux[3] = 1'b0;
    cyc(5);
    rchk(8'h62, 16'h0008, "R4");

    // R8 disabling leaves status in place
    wreg(8'h5E, 16'h0000);
    wreg(8'h60, 16'h0000);
    cyc(2);
    rchk(8'h62, 16'h0008, "R8");
    irqchk(1'b1, "R8");

    // R6 full clear of several bits
    wreg(8'h5E, 16'hFFFF);
    @(negedge clk); aux = 16'h00F1;
    cyc(5);
    rchk(8'h62, 16'h00F9, "R2");
    wreg(8'h62, 16'hFFFF);
    cyc(1);
    rchk(8'h62, 16'h0000, "R6");
    irqchk(1'b0, "R6");
    wreg(8'h62, 16'h0000);

    // R9 unknown addresses: writes ignored, reads zero
    wreg(8'h10, 16'h1234);
    rchk(8'h5E, 16'hFFFF, "R9");
    rchk(8'h60, 16'h0000, "R9");
    rchk(8'h10, 16'h0000, "R9");

    cyc(4);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule